// File: doc/BRIEF.md
# Two-Tier Rotating Bus Arbiter

Central arbiter for a shared parallel bus with nine requesters. Requester 0 is the internal bridge master and requesters 1 to 8 are external masters. Each requester has a request input and a one-hot grant output. A group register gives every master one bit that places it in the high group or the low group. The high group rotates round-robin. The low group as a whole fills one extra slot in that rotation, and its members rotate among themselves inside that slot.

The arbiter recomputes priority at each transaction start, which `frame_start_i` marks. Between starts it grants the best asserted request, and a better request takes the grant away. A granted master that never starts a transaction loses its grant after a fixed number of idle clocks and is locked out until it releases its request. On an idle bus, the grant never passes directly from one master to another in a single clock.

Top module: `two_tier_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is set in any clock. When no request is asserted, the grant parks on master 0 (bit 0 of `gnt_o`).
- R2: Bit i of `grp_wdata_i` = 1 puts master i in the high group and 0 puts it in the low group. A value written with `grp_we_i` is stored and becomes active at the next clock edge with `frame_start_i` high. Until then the old grouping stays in force.
- R3: With masters 0 to 3 high, masters 4 to 8 low and every request held, the owners of successive transactions follow the order 1,2,3,4,0,1,2,3,5,0,1,2 after a transaction started by master 0. The low group takes one slot after each pass of the high group.
- R4: At a frame start, the current grant holder becomes the lowest in its group, and the next master after it in index order becomes the highest. The high and low groups each keep their own rotation pointer.
- R5: If all masters are in one group, arbitration is a plain round-robin in index order. All high, after owner 0, gives 1,2,...,8,0,1. All low, loaded at a start owned by master 0 while it was still high, gives 0,1,...,8,0.
- R6: After reset, only master 0 is in the high group and the grant rests on master 0. With every request held, master 0 owns every other transaction, and the external masters rotate 1,2,3,4 in the remaining slots.
- R7: A higher-priority request takes the grant from a lower one. On a busy bus (`bus_idle_i` low), the new grant appears one clock later with no gap.
- R8: While `bus_idle_i` is high, a grant that changes first goes to all zero for one clock, then the new grant is set.
- R9: A master whose grant and request stay set on an idle bus for 16 clocks without a frame start loses the grant after the 16th clock. It gets no grant until it has held its request low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 9 | Request per master, bit 0 is the bridge |
| frame_start_i | input | 1 | High for the clock in which a new transaction starts |
| bus_idle_i | input | 1 | Bus carries no transaction |
| grp_we_i | input | 1 | Write strobe for the group register |
| grp_wdata_i | input | 9 | New group bits, 1 = high group |
| gnt_o | output | 9 | One-hot grant per master |

## Verification
Every grant decision is registered, so `gnt_o` reflects the inputs present at the previous rising edge. An idle-bus handover adds exactly one all-zero clock. A frame start changes priority only from the clock after its edge, so the sequence checks wait one quiet clock after each start before they read the owner. The timeout check counts the clocks in which the grant is visible and expects the drop on the seventeenth sample. The bench drives inputs and samples outputs on the falling edge. It advances its own cycle model once per rising edge, so every comparison lines up with the edge that produced the value.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Distance from `from` to `to` going forward around a ring, minus one.
  function automatic int ring_dist(input int from, input int to, input int size);
    return (to + size - from - 1) % size;
  endfunction
endpackage

// File: rtl/arb_rank.sv
module arb_rank
  import arb_pkg::*;
#(
  parameter int N_MST = 9
) (
  input  logic [N_MST-1:0]               elig_i,
  input  logic [N_MST-1:0]               grp_i,
  input  logic [$clog2(N_MST+1)-1:0]     last_hi_i,
  input  logic [$clog2(N_MST+1)-1:0]     last_lo_i,
  output logic [N_MST-1:0]               win_o,
  output logic                           any_o
);
  // Score = high-ring position * N_MST + low-ring position; the low slot sits at ring index N_MST.
  always_comb begin
    int best;
    int score;
    win_o = '0;
    any_o = 1'b0;
    best  = (N_MST + 1) * N_MST;
    for (int i = 0; i < N_MST; i++) begin
      if (grp_i[i]) score = ring_dist(int'(last_hi_i), i, N_MST + 1) * N_MST;
      else score = ring_dist(int'(last_hi_i), N_MST, N_MST + 1) * N_MST
                   + ring_dist(int'(last_lo_i), i, N_MST);
      if (elig_i[i] && score < best) begin
        best  = score;
        win_o = N_MST'(1) << i;
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_timeout.sv
module arb_timeout #(
  parameter int N_MST   = 9,
  parameter int TIMEOUT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] gnt_i,
  input  logic [N_MST-1:0] req_i,
  input  logic             bus_idle_i,
  input  logic             frame_start_i,
  output logic             expire_o,
  output logic [N_MST-1:0] blocked_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0]    cnt_q;
  logic [N_MST-1:0] blocked_q;
  logic             qual;

  // Idle-bus cycles with a live grant and no start; any gap clears the count.
  assign qual     = (|(gnt_i & req_i)) && bus_idle_i && !frame_start_i;
  assign expire_o = qual && (cnt_q == CW'(TIMEOUT - 1));
  assign blocked_o = blocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      blocked_q <= '0;
    end else begin
      cnt_q     <= (qual && !expire_o) ? cnt_q + CW'(1) : '0;
      blocked_q <= (blocked_q | (expire_o ? gnt_i : '0)) & req_i;
    end
  end

  p_blocked_no_gnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_q & gnt_i) == '0);
  p_expire_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (gnt_i & $past(gnt_i)) == '0);
endmodule

// File: rtl/two_tier_arbiter.sv
module two_tier_arbiter #(
  parameter int N_MST   = 9,
  parameter int TIMEOUT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic             frame_start_i,
  input  logic             bus_idle_i,
  input  logic             grp_we_i,
  input  logic [N_MST-1:0] grp_wdata_i,
  output logic [N_MST-1:0] gnt_o
);
  localparam int IW = $clog2(N_MST + 1);
  localparam logic [N_MST-1:0] PARK = N_MST'(1);

  logic [N_MST-1:0] grp_shd_q, grp_act_q, gnt_q, gnt_d;
  logic [N_MST-1:0] blocked, kill, elig, win, target;
  logic [IW-1:0]    last_hi_q, last_lo_q, owner_idx;
  logic             expire, win_any;

  arb_timeout #(.N_MST(N_MST), .TIMEOUT(TIMEOUT)) u_timeout (
    .clk_i, .rst_ni, .gnt_i(gnt_q), .req_i, .bus_idle_i, .frame_start_i,
    .expire_o(expire), .blocked_o(blocked)
  );

  assign kill = expire ? gnt_q : '0;
  assign elig = req_i & ~blocked & ~kill;

  arb_rank #(.N_MST(N_MST)) u_rank (
    .elig_i(elig), .grp_i(grp_act_q), .last_hi_i(last_hi_q), .last_lo_i(last_lo_q),
    .win_o(win), .any_o(win_any)
  );

  assign target = win_any ? win : ((req_i == '0) ? PARK : '0);
  // Idle bus: a handover passes through one grant-free clock.
  assign gnt_d  = (bus_idle_i && (|gnt_q) && target != gnt_q) ? '0 : target;
  assign gnt_o  = gnt_q;

  always_comb begin
    owner_idx = '0;
    for (int i = 0; i < N_MST; i++) if (gnt_q[i]) owner_idx = IW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q     <= PARK;
      grp_shd_q <= PARK;
      grp_act_q <= PARK;
      last_hi_q <= IW'(N_MST);
      last_lo_q <= IW'(N_MST - 1);
    end else begin
      gnt_q <= gnt_d;
      if (grp_we_i) grp_shd_q <= grp_wdata_i;
      if (frame_start_i) begin
        grp_act_q <= grp_shd_q;
        if (|gnt_q) begin
          if (grp_act_q[owner_idx]) last_hi_q <= owner_idx;
          else begin
            last_hi_q <= IW'(N_MST);
            last_lo_q <= owner_idx;
          end
        end
      end
    end
  end

  p_gnt_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  p_park_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && gnt_q == '0) |=> gnt_q == PARK);
  p_dead_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_i && gnt_q != '0) |=> (gnt_q == '0 || gnt_q == $past(gnt_q)));
  p_grp_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(grp_act_q));
endmodule

// File: tb/two_tier_arbiter_tb_top.sv
`timescale 1ns/1ps
module two_tier_arbiter_tb_top;
  localparam int N  = 9;
  localparam int TO = 16;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req, wdata, gnt;
  logic         fs, idle, we;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  // model state
  logic [N-1:0] m_gnt, m_blk, m_act, m_sh;
  int m_cnt, m_lh, m_ll;

  always #2 clk = ~clk;

  two_tier_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .frame_start_i(fs), .bus_idle_i(idle),
    .grp_we_i(we), .grp_wdata_i(wdata), .gnt_o(gnt)
  );

  function automatic int rd(input int from, input int to, input int size);
    return (to + size - from - 1) % size;
  endfunction

  task automatic model_step(input logic [N-1:0] r, input logic i_idle, input logic i_fs,
                            input logic i_we, input logic [N-1:0] i_wd);
    logic qual, ex;
    logic [N-1:0] kill, elig, tgt, ng;
    int best, bs, s;
    qual = ((m_gnt & r) != '0) && i_idle && !i_fs;
    ex   = qual && (m_cnt == TO - 1);
    kill = ex ? m_gnt : '0;
    elig = r & ~m_blk & ~kill;
    best = -1;
    bs   = 1 << 30;
    for (int i = 0; i < N; i++) begin
      s = m_act[i] ? rd(m_lh, i, N + 1) * N : rd(m_lh, N, N + 1) * N + rd(m_ll, i, N);
      if (elig[i] && s < bs) begin bs = s; best = i; end
    end
    tgt = (best >= 0) ? (N'(1) << best) : ((r == '0) ? N'(1) : '0);
    ng  = (i_idle && m_gnt != '0 && tgt != m_gnt) ? '0 : tgt;
    if (i_fs && m_gnt != '0) begin
      for (int i = 0; i < N; i++) if (m_gnt[i]) begin
        if (m_act[i]) m_lh = i;
        else begin m_lh = N; m_ll = i; end
      end
    end
    if (i_fs) m_act = m_sh;
    if (i_we) m_sh = i_wd;
    m_cnt = (qual && !ex) ? m_cnt + 1 : 0;
    m_blk = (m_blk | kill) & r;
    m_gnt = ng;
  endtask

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Check current outputs against model, apply inputs for one edge, land on next falling edge.
  task automatic step(input logic [N-1:0] r, input logic i_idle, input logic i_fs,
                      input logic i_we = 1'b0, input logic [N-1:0] i_wd = '0);
    chk(gnt, m_gnt, "R1 R7 R8 R9 cycle model");
    tests++;
    if ($countones(gnt) > 1) begin
      fails++;
      $display("FAIL R1: got %b expected at most one bit", gnt);
    end
    req = r; idle = i_idle; fs = i_fs; we = i_we; wdata = i_wd;
    model_step(r, i_idle, i_fs, i_we, i_wd);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; idle = 1'b1; fs = 1'b0; we = 1'b0; wdata = '0;
    m_gnt = N'(1); m_blk = '0; m_act = N'(1); m_sh = N'(1); m_cnt = 0; m_lh = N; m_ll = N - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One transaction per pair of clocks: start owned by current holder, then a quiet clock.
  task automatic owner_seq(input int n, input int exp_q[12], input string tag);
    for (int k = 0; k < n; k++) begin
      step(ALL, 1'b0, 1'b1);
      step(ALL, 1'b0, 1'b0);
      chk(gnt, N'(1) << exp_q[k], tag);
    end
  endtask

  initial begin
    int n_hi;
    int s_r3[12] = '{1, 2, 3, 4, 0, 1, 2, 3, 5, 0, 1, 2};
    int s_hi[12] = '{1, 2, 3, 4, 5, 6, 7, 8, 0, 1, 0, 0};
    int s_lo[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 0, 0, 0};
    int s_r6[12] = '{1, 0, 2, 0, 3, 0, 4, 0, 0, 0, 0, 0};
    void'($urandom(32'h1A2B));

    // R6 reset state
    do_reset();
    chk(gnt, 9'h001, "R6 reset grant on bridge");
    step(ALL, 1'b0, 1'b0);
    chk(gnt, 9'h001, "R6 bridge first after reset");
    owner_seq(8, s_r6, "R6 bridge every other");

    // R3 / R4 nested rotation
    do_reset();
    step(ALL, 1'b0, 1'b0);
    step(ALL, 1'b0, 1'b0, 1'b1, 9'h00F);
    owner_seq(12, s_r3, "R3 R4 nested order");

    // R5 fallback, all high
    do_reset();
    step(ALL, 1'b0, 1'b0);
    step(ALL, 1'b0, 1'b0, 1'b1, 9'h1FF);
    owner_seq(10, s_hi, "R5 all high round-robin");

    // R5 fallback, all low
    do_reset();
    step(ALL, 1'b0, 1'b0);
    step(ALL, 1'b0, 1'b0, 1'b1, 9'h000);
    owner_seq(10, s_lo, "R5 all low round-robin");

    // R2 write held until frame start
    do_reset();
    step(9'h061, 1'b0, 1'b0);
    chk(gnt, 9'h001, "R2 default grouping");
    step(9'h061, 1'b0, 1'b0, 1'b1, 9'h000);
    step(9'h061, 1'b0, 1'b0);
    chk(gnt, 9'h001, "R2 no change before start");
    step(9'h061, 1'b0, 1'b1);
    step(9'h061, 1'b0, 1'b0);
    chk(gnt, 9'h001, "R2 new grouping after start");
    step(9'h061, 1'b0, 1'b1);
    step(9'h061, 1'b0, 1'b0);
    chk(gnt, 9'h020, "R2 R4 low rotation");
    step(9'h061, 1'b0, 1'b1);
    step(9'h061, 1'b0, 1'b0);
    chk(gnt, 9'h040, "R2 R4 low rotation next");

    // R7 busy preemption, R8 idle handover
    do_reset();
    step(9'h008, 1'b0, 1'b0);
    chk(gnt, 9'h008, "R7 busy direct grant");
    step(9'h009, 1'b0, 1'b0);
    chk(gnt, 9'h001, "R7 preempt next clock");
    step(9'h008, 1'b1, 1'b0);
    chk(gnt, 9'h000, "R8 idle gap");
    step(9'h008, 1'b1, 1'b0);
    chk(gnt, 9'h008, "R8 grant after gap");
    step(9'h009, 1'b1, 1'b0);
    chk(gnt, 9'h000, "R8 idle gap on preempt");
    step(9'h009, 1'b1, 1'b0);
    chk(gnt, 9'h001, "R7 preempt on idle bus");

    // R9 timeout and lockout
    do_reset();
    step(9'h020, 1'b1, 1'b0);
    n_hi = 0;
    for (int k = 0; k < 40; k++) begin
      step(9'h020, 1'b1, 1'b0);
      if (gnt == 9'h020) n_hi++;
      else if (n_hi > 0) break;
    end
    tests++;
    if (n_hi != TO) begin
      fails++;
      $display("FAIL R9: got %0d granted clocks expected %0d", n_hi, TO);
    end
    repeat (3) step(9'h020, 1'b1, 1'b0);
    chk(gnt, 9'h000, "R9 locked out");
    step(9'h000, 1'b1, 1'b0);
    chk(gnt, 9'h001, "R9 R1 park after release");
    step(9'h020, 1'b1, 1'b0);
    step(9'h020, 1'b1, 1'b0);
    chk(gnt, 9'h020, "R9 grant again after release");

    // random traffic against the cycle model
    do_reset();
    begin
      logic [N-1:0] r = '0;
      for (int k = 0; k < 4000; k++) begin
        if ($urandom % 10 == 0) r = N'($urandom);
        step(r, ($urandom % 4) != 0, ($urandom % 7) == 0,
             ($urandom % 60) == 0, N'($urandom));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule